// File: doc/BRIEF.md
# Fail-Safe Clock Monitor Controller

This controller supervises a primary oscillator and moves the system onto an internal backup clock when the primary stops running. The primary is represented by a synchronized activity line that changes level on primary edges. A slow sample tick opens consecutive observation windows. A window that closes with no change on the activity line counts as a failure. The controller then selects the backup clock, sets a sticky failure flag and can raise an interrupt. It does not switch back to the primary by itself.

After reset, a power-on event or a wake event, the controller runs a start-up phase. For an external-clock or internal-oscillator primary, monitoring starts on the next clock. For a crystal primary, with or without a PLL, the backup clock runs the system until the start-up timer has expired, and for the PLL variant the PLL timer as well. Only then does the primary take over and monitoring begin. A low-power request made during this wait parks the select on the low-power source. The clock multiplexer and the oscillators themselves are outside this block. Clock selection appears only as a select code.

Top module: `clk_fail_guard`

## Requirements
- R1: While reset is asserted, clkSel is 2'b01 (backup), and failFlag, irqReq and primStable are 0.
- R2: With oscMode 2'b00 (external clock) or 2'b01 (internal oscillator), one clock after reset release or after a por/wake event, clkSel is 2'b00 (primary) and primStable is 1.
- R3: With oscMode 2'b10 (crystal), clkSel stays 2'b01 until ostDone is 1, and pllDone has no effect. With oscMode 2'b11 (crystal with PLL), both ostDone and pllDone must be 1. One clock after the condition holds, clkSel is 2'b00 and primStable is 1.
- R4: While monitoring, a sampleTick with no change of primToggle since the previous tick is a failure. On the next clock, clkSel is 2'b01, failFlag is 1 and primStable is 0. The first ARM_TICKS ticks after monitoring starts only arm the check and never fail.
- R5: While monitoring, a change of primToggle between two ticks prevents a failure at the second tick.
- R6: After a failure, clkSel remains 2'b01 regardless of primToggle, ticks, flagClr or irqEn, until a porEvent or wakeEvent restarts start-up.
- R7: irqReq is 1 exactly when failFlag is 1 and irqEn is 1.
- R8: failFlag is cleared only by flagClr or reset, and never by a por/wake event. A failure and flagClr in the same cycle leave the flag set.
- R9: During the start-up wait no failure is detected, whatever the ticks and primToggle do. A primary that never becomes ready only leaves primStable at 0.
- R10: When lowPwrReq is 1 during a crystal start-up wait, clkSel becomes 2'b10 (low-power source) and stays there, ignoring ostDone and pllDone, until a por/wake event.
- R11: A porEvent or wakeEvent in any state restarts the start-up phase on the next clock. clkSel is 2'b01 and primStable is 0 until the mode's ready condition holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleTick | input | 1 | One-cycle strobe that closes an observation window |
| primToggle | input | 1 | Synchronized primary activity line; any level change is activity |
| oscMode | input | 2 | Primary mode: 00 external, 01 internal, 10 crystal, 11 crystal with PLL |
| porEvent | input | 1 | Power-on event strobe; restarts start-up |
| wakeEvent | input | 1 | Wake-from-sleep strobe; restarts start-up |
| ostDone | input | 1 | Oscillator start-up timer expired |
| pllDone | input | 1 | PLL lock timer expired |
| lowPwrReq | input | 1 | Request for the low-power clock source |
| irqEn | input | 1 | Failure interrupt enable |
| flagClr | input | 1 | Clears the failure flag |
| clkSel | output | 2 | 00 primary, 01 backup, 10 low-power source |
| failFlag | output | 1 | Sticky failure flag |
| irqReq | output | 1 | Failure interrupt request |
| primStable | output | 1 | Primary running and monitored |

## Verification
Detection is driven with windows that each hold one activity change, with windows that hold none, and with a silent first window right after monitoring begins. These separate a real failure from the arming window and from a primary that is still running. Start-up is tried in every mode with the timer inputs held in combinations where only the mode-relevant ones may release the wait. A silent primary is also applied during the wait, which shows that detection is held off then. Clear, enable, event and low-power stimulus applied after a failure and during the wait shows that the select never returns on its own and that flag handling is independent of clock selection.

// File: rtl/clk_fail_guard_pkg.sv
package clk_fail_guard_pkg;

  localparam int MODE_W = 2;
  localparam int SEL_W  = 2;

  typedef enum logic [MODE_W-1:0] {
    MODE_EXT  = 2'b00,
    MODE_INT  = 2'b01,
    MODE_XTAL = 2'b10,
    MODE_XPLL = 2'b11
  } oscMode_t;

  typedef enum logic [SEL_W-1:0] {
    SEL_PRIM   = 2'b00,
    SEL_BACKUP = 2'b01,
    SEL_LOWPWR = 2'b10
  } clkSel_t;

  typedef enum logic [1:0] {
    ST_WAIT = 2'b00,
    ST_MON  = 2'b01,
    ST_FAIL = 2'b10,
    ST_PARK = 2'b11
  } guardState_t;

  typedef struct packed {
    logic watch;       // monitoring window active
    logic raiseFail;   // set the sticky failure flag
    logic setStable;   // primary has just taken over
    logic dropStable;  // primary no longer in use
  } guardStrobe_t;

endpackage

// File: rtl/clk_fail_guard_ctrl.sv
module clk_fail_guard_ctrl
  import clk_fail_guard_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [MODE_W-1:0]  oscMode,
  input  logic               porEvent,
  input  logic               wakeEvent,
  input  logic               ostDone,
  input  logic               pllDone,
  input  logic               lowPwrReq,
  input  logic               missTick,
  output guardStrobe_t       strobe,
  output logic [SEL_W-1:0]   clkSel,
  output guardState_t        state
);

  guardState_t nextState;
  logic        restart;
  logic        fastMode;
  logic        readyNow;

  always_comb begin
    restart  = porEvent | wakeEvent;
    fastMode = (oscMode == MODE_EXT) || (oscMode == MODE_INT);
    // PLL timer only matters in the PLL crystal mode
    readyNow = fastMode ||
               (ostDone && ((oscMode != MODE_XPLL) || pllDone));
  end

  always_comb begin
    nextState = state;
    unique case (state)
      ST_WAIT: begin
        if (lowPwrReq && !fastMode) nextState = ST_PARK;
        else if (readyNow)          nextState = ST_MON;
      end
      ST_MON:  if (missTick) nextState = ST_FAIL;
      ST_FAIL: nextState = ST_FAIL;
      ST_PARK: nextState = ST_PARK;
      default: nextState = ST_WAIT;
    endcase
    if (restart) nextState = ST_WAIT;
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_WAIT;
    else       state <= nextState;
  end

  always_comb begin
    strobe.watch      = (state == ST_MON);
    strobe.raiseFail  = (state == ST_MON) && missTick && !restart;
    strobe.setStable  = (nextState == ST_MON) && (state != ST_MON);
    strobe.dropStable = (nextState != ST_MON);
  end

  always_comb begin
    unique case (state)
      ST_MON:  clkSel = SEL_PRIM;
      ST_PARK: clkSel = SEL_LOWPWR;
      default: clkSel = SEL_BACKUP;
    endcase
  end

endmodule

// File: rtl/clk_fail_guard_dp.sv
module clk_fail_guard_dp
  import clk_fail_guard_pkg::*;
#(
  parameter int ARM_TICKS = 1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         sampleTick,
  input  logic         primToggle,
  input  logic         irqEn,
  input  logic         flagClr,
  input  guardStrobe_t strobe,
  output logic         missTick,
  output logic         failFlag,
  output logic         irqReq,
  output logic         primStable
);

  localparam int ARM_W = $clog2(ARM_TICKS + 1);
  localparam logic [ARM_W-1:0] ARM_LAST = ARM_W'(ARM_TICKS);

  logic             prevTog;
  logic             seenAct;
  logic             actEdge;
  logic             armed;
  logic [ARM_W-1:0] armCnt;

  always_comb begin
    actEdge  = primToggle ^ prevTog;
    armed    = (armCnt == ARM_LAST);
    missTick = strobe.watch && sampleTick && armed && !seenAct && !actEdge;
  end

  always_ff @(posedge clk) begin
    if (!rstN) prevTog <= 1'b0;
    else       prevTog <= primToggle;
  end

  // activity observation: reset per window, armed after ARM_TICKS ticks
  always_ff @(posedge clk) begin
    if (!rstN || !strobe.watch) begin
      seenAct <= 1'b0;
      armCnt  <= '0;
    end else if (sampleTick) begin
      seenAct <= 1'b0;
      if (!armed) armCnt <= armCnt + 1'b1;
    end else if (actEdge) begin
      seenAct <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 failFlag <= 1'b0;
    else if (strobe.raiseFail) failFlag <= 1'b1;
    else if (flagClr)          failFlag <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                  primStable <= 1'b0;
    else if (strobe.setStable)  primStable <= 1'b1;
    else if (strobe.dropStable) primStable <= 1'b0;
  end

  always_comb irqReq = failFlag & irqEn;

endmodule

// File: rtl/clk_fail_guard.sv
module clk_fail_guard
  import clk_fail_guard_pkg::*;
#(
  parameter int ARM_TICKS = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleTick,
  input  logic              primToggle,
  input  logic [MODE_W-1:0] oscMode,
  input  logic              porEvent,
  input  logic              wakeEvent,
  input  logic              ostDone,
  input  logic              pllDone,
  input  logic              lowPwrReq,
  input  logic              irqEn,
  input  logic              flagClr,
  output logic [SEL_W-1:0]  clkSel,
  output logic              failFlag,
  output logic              irqReq,
  output logic              primStable
);

  guardStrobe_t strobe;
  guardState_t  ctrlState;
  logic         missTick;

  clk_fail_guard_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .oscMode   (oscMode),
    .porEvent  (porEvent),
    .wakeEvent (wakeEvent),
    .ostDone   (ostDone),
    .pllDone   (pllDone),
    .lowPwrReq (lowPwrReq),
    .missTick  (missTick),
    .strobe    (strobe),
    .clkSel    (clkSel),
    .state     (ctrlState)
  );

  clk_fail_guard_dp #(.ARM_TICKS(ARM_TICKS)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .sampleTick (sampleTick),
    .primToggle (primToggle),
    .irqEn      (irqEn),
    .flagClr    (flagClr),
    .strobe     (strobe),
    .missTick   (missTick),
    .failFlag   (failFlag),
    .irqReq     (irqReq),
    .primStable (primStable)
  );

endmodule

// File: rtl/clk_fail_guard_checker.sv
module clk_fail_guard_checker
  import clk_fail_guard_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              porEvent,
  input logic              wakeEvent,
  input logic              flagClr,
  input logic [SEL_W-1:0]  clkSel,
  input logic              failFlag,
  input logic              primStable,
  input guardState_t       ctrlState
);

  // R4: a new failure comes with the backup select and stable dropped
  a_r4_fail_moves_to_backup: assert property (@(posedge clk) disable iff (!rstN)
    $rose(failFlag) |-> (clkSel == SEL_BACKUP) && !primStable);

  // R6: the failed state is left only through a restart event
  a_r6_no_auto_return: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlState == ST_FAIL && !porEvent && !wakeEvent) |=> (clkSel == SEL_BACKUP));

  // R8: flag holds until an explicit clear
  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (failFlag && !flagClr) |=> failFlag);

  // R9: no detection outside monitoring
  a_r9_no_fail_in_wait: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlState != ST_MON) |=> !$rose(failFlag));

  // R3: stable status only while running on the primary
  a_r3_stable_on_primary: assert property (@(posedge clk) disable iff (!rstN)
    primStable |-> (clkSel == SEL_PRIM));

  // R10: parked select holds until a restart event
  a_r10_park_holds: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlState == ST_PARK && !porEvent && !wakeEvent) |=> (clkSel == SEL_LOWPWR));

  // R11: a restart event always leads to the backup select
  a_r11_restart_backup: assert property (@(posedge clk) disable iff (!rstN)
    (porEvent || wakeEvent) |=> (clkSel == SEL_BACKUP) && !primStable);

endmodule

bind clk_fail_guard clk_fail_guard_checker u_checker (
  .clk        (clk),
  .rstN       (rstN),
  .porEvent   (porEvent),
  .wakeEvent  (wakeEvent),
  .flagClr    (flagClr),
  .clkSel     (clkSel),
  .failFlag   (failFlag),
  .primStable (primStable),
  .ctrlState  (ctrlState)
);

// File: tb/clk_fail_guard_bench.sv
`timescale 1ns/1ps
module clk_fail_guard_bench;

  logic       clk = 1'b0;
  logic       rstN, sampleTick, primToggle, porEvent, wakeEvent;
  logic       ostDone, pllDone, lowPwrReq, irqEn, flagClr;
  logic [1:0] oscMode;
  logic [1:0] clkSel;
  logic       failFlag, irqReq, primStable;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  clk_fail_guard u_clk_fail_guard (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .primToggle(primToggle),
    .oscMode(oscMode), .porEvent(porEvent), .wakeEvent(wakeEvent),
    .ostDone(ostDone), .pllDone(pllDone), .lowPwrReq(lowPwrReq),
    .irqEn(irqEn), .flagClr(flagClr), .clkSel(clkSel), .failFlag(failFlag),
    .irqReq(irqReq), .primStable(primStable)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doReset(input logic [1:0] mode);
    @(negedge clk);
    rstN = 1'b0; oscMode = mode; sampleTick = 1'b0; primToggle = 1'b0;
    porEvent = 1'b0; wakeEvent = 1'b0; lowPwrReq = 1'b0; flagClr = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 clkSel", clkSel, 1);
    chk("R1 failFlag", failFlag, 0);
    chk("R1 irqReq", irqReq, 0);
    chk("R1 primStable", primStable, 0);
    rstN = 1'b1;
  endtask

  task automatic tick();
    sampleTick = 1'b1;
    @(negedge clk);
    sampleTick = 1'b0;
  endtask

  task automatic toggle();
    primToggle = ~primToggle;
    @(negedge clk);
  endtask

  task automatic pulseEvent(input bit wake);
    if (wake) wakeEvent = 1'b1; else porEvent = 1'b1;
    @(negedge clk);
    wakeEvent = 1'b0; porEvent = 1'b0;
  endtask

  task automatic t_extRunAndFail();
    irqEn = 1'b1; ostDone = 1'b0; pllDone = 1'b0;
    doReset(2'b00);
    @(negedge clk);
    chk("R2 ext clkSel", clkSel, 0);
    chk("R2 ext primStable", primStable, 1);
    tick();  // arming window, silent
    chk("R4 arm tick no fail", clkSel, 0);
    for (int i = 0; i < 3; i++) begin
      toggle();
      tick();
    end
    chk("R5 active clkSel", clkSel, 0);
    chk("R5 active failFlag", failFlag, 0);
    tick();  // silent window
    chk("R4 fail clkSel", clkSel, 1);
    chk("R4 fail failFlag", failFlag, 1);
    chk("R4 fail primStable", primStable, 0);
    chk("R7 irq with enable", irqReq, 1);
    for (int i = 0; i < 2; i++) begin
      toggle();
      tick();
    end
    flagClr = 1'b1;
    @(negedge clk);
    flagClr = 1'b0;
    chk("R6 clkSel after clear", clkSel, 1);
    chk("R8 flag cleared", failFlag, 0);
    chk("R7 irq after clear", irqReq, 0);
  endtask

  task automatic t_intIrqOff();
    irqEn = 1'b0;
    doReset(2'b01);
    @(negedge clk);
    chk("R2 int clkSel", clkSel, 0);
    tick();
    flagClr = 1'b1;
    tick();  // failure with clear held
    flagClr = 1'b0;
    chk("R8 set wins over clear", failFlag, 1);
    chk("R7 irq disabled", irqReq, 0);
    irqEn = 1'b1;
    @(negedge clk);
    chk("R7 irq enabled later", irqReq, 1);
    pulseEvent(1'b0);
    chk("R11 por restart clkSel", clkSel, 1);
    chk("R8 flag kept over event", failFlag, 1);
    @(negedge clk);
    chk("R6 primary only after event", clkSel, 0);
  endtask

  task automatic t_xtal();
    irqEn = 1'b1; ostDone = 1'b0; pllDone = 1'b1;
    doReset(2'b10);
    for (int i = 0; i < 5; i++) tick();
    chk("R3 xtal waits, pllDone ignored", clkSel, 1);
    chk("R9 silent primary no flag", failFlag, 0);
    chk("R9 primStable low", primStable, 0);
    ostDone = 1'b1;
    @(negedge clk);
    chk("R3 xtal ready clkSel", clkSel, 0);
    chk("R3 xtal ready primStable", primStable, 1);
    ostDone = 1'b0;
    pulseEvent(1'b1);
    chk("R11 wake restart clkSel", clkSel, 1);
    chk("R11 wake restart primStable", primStable, 0);
    for (int i = 0; i < 3; i++) tick();
    chk("R9 no fail after wake", failFlag, 0);
  endtask

  task automatic t_pll();
    ostDone = 1'b1; pllDone = 1'b0;
    doReset(2'b11);
    for (int i = 0; i < 3; i++) tick();
    chk("R3 pll waits for pllDone", clkSel, 1);
    pllDone = 1'b1;
    @(negedge clk);
    chk("R3 pll ready clkSel", clkSel, 0);
    chk("R3 pll ready primStable", primStable, 1);
  endtask

  task automatic t_lowPower();
    ostDone = 1'b0; pllDone = 1'b0;
    doReset(2'b10);
    lowPwrReq = 1'b1;
    @(negedge clk);
    chk("R10 low-power select", clkSel, 2);
    ostDone = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10 timers ignored", clkSel, 2);
    chk("R10 primStable low", primStable, 0);
    lowPwrReq = 1'b0;
    @(negedge clk);
    chk("R10 held after request drops", clkSel, 2);
    pulseEvent(1'b1);
    chk("R11 wake from park", clkSel, 1);
    @(negedge clk);
    chk("R11 primary after wake", clkSel, 0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rstN = 1'b0; oscMode = 2'b00; sampleTick = 1'b0; primToggle = 1'b0;
    porEvent = 1'b0; wakeEvent = 1'b0; ostDone = 1'b0; pllDone = 1'b0;
    lowPwrReq = 1'b0; irqEn = 1'b0; flagClr = 1'b0;
    t_extRunAndFail();
    t_intIrqOff();
    t_xtal();
    t_pll();
    t_lowPower();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule